// File: doc/BRIEF.md
# Flash Status Register Protection Controller

This block holds the status register of a serial NOR flash and decides, cycle by cycle, whether each decoded command may proceed. The command decoder in front of it presents one-cycle strobes for write-enable, write-disable, status write (with its 24-bit data), page program, sector erase (both with a byte address), chip erase and status read. A timer behind it returns a one-cycle completion pulse when a high-voltage operation ends. The block answers each strobe with a registered accept or reject pulse and drives a busy flag and the live status word.

Status writes are governed by a two-bit lock mode combined with the level of a protect pin. One mode is released only by a power cycle, and another is permanent. Program and erase are refused when their address lies in the protected top region that the protection level field selects, or in its complement when the invert bit is set. Chip erase requires the protection level to be zero and the invert bit to be clear. The synchronous reset input models a power cycle: the volatile bits clear, and the non-volatile bits keep their values.

Top module: `flash_sr_guard`

## Requirements
- R1: An accepted status write stores its data bits 2 to 9, 14, 18 and 21 to 23 (protection level in bits 6:2, lock mode in bits 8:7 with bit 7 as the low bit, quad enable bit 9, invert bit 14). Bits 10 to 13, 15 to 17, 19 and 20 always read 0.
- R2: Write-enable sets bit 1 (the write latch) and write-disable clears it. Both are accepted.
- R3: An accepted status write, program, sector erase or chip erase sets bit 0 and busy on the following cycle. Both stay 1 until the cycle after the completion pulse, which also clears bit 1.
- R4: With bit 1 at 0, status write, program, sector erase and chip erase are rejected. Any rejection of these four commands clears bit 1.
- R5: Lock mode 00 lets a status write proceed whenever bit 1 is 1. In mode 01 a status write proceeds only while prot_pin_n is high. Modes 10 and 11 reject every status write.
- R6: A reset cycle clears bits 0 and 1 and keeps all other bits. It changes lock mode 10 to 00 and leaves mode 11 unchanged.
- R7: Chip erase is accepted only when bits 6:2 are 0, bit 14 is 0 and bit 1 is 1. Otherwise it is rejected.
- R8: For program and sector erase, a nonzero protection level L protects the top min(2^(L-1), all) blocks, where a block is 2^BLK_W bytes. Setting bit 14 protects the complement of that region instead. An address in the protected region is rejected.
- R9: While busy, every strobe except status read is ignored: there is no accept and no reject pulse, and the status stays unchanged until the completion pulse. A status read is accepted at any time.
- R10: Every strobe that is not ignored produces exactly one of cmd_accept or cmd_reject for exactly one cycle, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-cycle reset |
| prot_pin_n | input | 1 | External write-protect level, active low |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 24 | Data for a status write |
| cmd_prog | input | 1 | Page program strobe |
| cmd_erase | input | 1 | Sector/block erase strobe |
| cmd_chip_erase | input | 1 | Chip erase strobe |
| cmd_rdsr | input | 1 | Status read strobe |
| op_addr | input | ADDR_W | Byte address for program or erase |
| op_done | input | 1 | Completion pulse from the operation timer |
| status | output | 24 | Live status register |
| busy | output | 1 | Operation in progress |
| cmd_accept | output | 1 | Command accepted pulse |
| cmd_reject | output | 1 | Command rejected pulse |

## Verification
The assertions check on every cycle that accept and reject never coincide, and that busy only rises together with an accept that found the write latch set. They also check that the status is frozen while busy without completion, that a completion pulse clears busy and the latch, that lock mode 11 never leaves, and that an accepted chip erase saw a zero protection level and a clear invert bit. Only the bench's scenarios can show the full region arithmetic swept over protection levels, invert settings and every block, the four lock modes against the pin, and the values that survive a reset.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
    localparam int SR_W = 24;

    // bit positions the decoder and host rely on
    localparam int BIT_BUSY  = 0;
    localparam int BIT_WLAT  = 1;
    localparam int LVL_LO    = 2;
    localparam int LVL_HI    = 6;
    localparam int LOCK_LO   = 7;
    localparam int LOCK_HI   = 8;
    localparam int BIT_INV   = 14;

    // bits a status write may change
    localparam logic [SR_W-1:0] WR_MASK = 24'hE443FC;

    typedef enum logic [1:0] {
        LOCK_SOFT = 2'b00,
        LOCK_PIN  = 2'b01,
        LOCK_PWR  = 2'b10,
        LOCK_PERM = 2'b11
    } lock_mode_e;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            acc;
        logic            rej;
    } guard_state_t;
endpackage

// File: rtl/sr_write_gate.sv
module sr_write_gate
    import flash_sr_pkg::*;
(
    input  logic [1:0] lock,
    input  logic       pin_n,
    input  logic       wlat,
    output logic       allow
);
    always_comb begin
        unique case (lock_mode_e'(lock))
            LOCK_SOFT: allow = wlat;
            LOCK_PIN:  allow = wlat & pin_n;
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/region_guard.sv
module region_guard #(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [4:0]        lvl,
    input  logic              inv,
    output logic              prot
);
    localparam int NB = ADDR_W - BLK_W;
    localparam logic [NB:0] NBLK = (NB+1)'(1) << NB;

    logic [NB:0] blk;
    logic [NB:0] span;
    logic        whole;
    logic        in_top;

    assign blk = {1'b0, addr[ADDR_W-1:BLK_W]};

    always_comb begin
        whole  = (32'(lvl) > NB);
        span   = (lvl == 5'd0 || whole) ? '0 : ((NB+1)'(1) << (lvl - 5'd1));
        in_top = (lvl != 5'd0) && (whole || blk >= (NBLK - span));
        prot   = in_top ^ inv;
    end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import flash_sr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_pin_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [SR_W-1:0]   wrsr_data,
    input  logic              cmd_prog,
    input  logic              cmd_erase,
    input  logic              cmd_chip_erase,
    input  logic              cmd_rdsr,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              op_done,
    output logic [SR_W-1:0]   status,
    output logic              busy,
    output logic              cmd_accept,
    output logic              cmd_reject
);
    guard_state_t state_q = '0;
    guard_state_t state_d;

    logic sr_allow;
    logic addr_prot;
    logic wlat;

    assign wlat = state_q.sr[BIT_WLAT];

    sr_write_gate u_gate (
        .lock  (state_q.sr[LOCK_HI:LOCK_LO]),
        .pin_n (prot_pin_n),
        .wlat  (wlat),
        .allow (sr_allow)
    );

    region_guard #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_region (
        .addr (op_addr),
        .lvl  (state_q.sr[LVL_HI:LVL_LO]),
        .inv  (state_q.sr[BIT_INV]),
        .prot (addr_prot)
    );

    always_comb begin
        state_d     = state_q;
        state_d.acc = 1'b0;
        state_d.rej = 1'b0;
        if (!rst_n) begin
            state_d.sr[BIT_BUSY] = 1'b0;
            state_d.sr[BIT_WLAT] = 1'b0;
            if (state_q.sr[LOCK_HI:LOCK_LO] == LOCK_PWR)
                state_d.sr[LOCK_HI:LOCK_LO] = LOCK_SOFT;
        end else if (state_q.sr[BIT_BUSY]) begin
            if (op_done) begin
                state_d.sr[BIT_BUSY] = 1'b0;
                state_d.sr[BIT_WLAT] = 1'b0;
            end
            state_d.acc = cmd_rdsr;
        end else if (cmd_rdsr) begin
            state_d.acc = 1'b1;
        end else if (cmd_wren) begin
            state_d.acc = 1'b1;
            state_d.sr[BIT_WLAT] = 1'b1;
        end else if (cmd_wrdi) begin
            state_d.acc = 1'b1;
            state_d.sr[BIT_WLAT] = 1'b0;
        end else if (cmd_wrsr) begin
            if (sr_allow) begin
                state_d.acc = 1'b1;
                state_d.sr  = (wrsr_data & WR_MASK) | (state_q.sr & ~WR_MASK);
                state_d.sr[BIT_BUSY] = 1'b1;
            end else begin
                state_d.rej = 1'b1;
                state_d.sr[BIT_WLAT] = 1'b0;
            end
        end else if (cmd_prog || cmd_erase) begin
            if (wlat && !addr_prot) begin
                state_d.acc = 1'b1;
                state_d.sr[BIT_BUSY] = 1'b1;
            end else begin
                state_d.rej = 1'b1;
                state_d.sr[BIT_WLAT] = 1'b0;
            end
        end else if (cmd_chip_erase) begin
            if (wlat && state_q.sr[LVL_HI:LVL_LO] == '0 && !state_q.sr[BIT_INV]) begin
                state_d.acc = 1'b1;
                state_d.sr[BIT_BUSY] = 1'b1;
            end else begin
                state_d.rej = 1'b1;
                state_d.sr[BIT_WLAT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign status     = state_q.sr;
    assign busy       = state_q.sr[BIT_BUSY];
    assign cmd_accept = state_q.acc;
    assign cmd_reject = state_q.rej;
endmodule

// File: rtl/flash_sr_guard_chk.sv
module flash_sr_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_chip_erase,
    input logic        cmd_rdsr,
    input logic        op_done,
    input logic [23:0] status,
    input logic        busy,
    input logic        cmd_accept,
    input logic        cmd_reject
);
    // R10
    excl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));

    // R3
    busy_rise_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cmd_accept);

    // R4
    busy_needs_wlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(status[1]));

    // R9
    busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !op_done |=> $stable(status) && !cmd_reject);

    // R3
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && op_done |=> !busy && !status[1]);

    // R6
    perm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[8:7] == 2'b11 |=> status[8:7] == 2'b11);

    // R7
    chip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_chip_erase && !cmd_rdsr |=> !cmd_accept ||
            ($past(status[6:2]) == 5'd0 && !$past(status[14])));
endmodule

bind flash_sr_guard flash_sr_guard_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_chip_erase (cmd_chip_erase),
    .cmd_rdsr       (cmd_rdsr),
    .op_done        (op_done),
    .status         (status),
    .busy           (busy),
    .cmd_accept     (cmd_accept),
    .cmd_reject     (cmd_reject)
);

// File: tb/tb_flash_sr_guard.sv
module tb_flash_sr_guard;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int BLK_W  = 12;
    localparam int NB     = ADDR_W - BLK_W;
    localparam int NBLK   = 1 << NB;
    localparam logic [23:0] MASK = 24'hE443FC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prot_pin_n = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_prog = 0;
    logic cmd_erase = 0, cmd_chip_erase = 0, cmd_rdsr = 0, op_done = 0;
    logic [23:0] wrsr_data = '0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [23:0] status;
    logic busy, cmd_accept, cmd_reject;

    int n_chk = 0;
    int n_fail = 0;
    logic got_acc, got_rej;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_sr_guard #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) dut (
        .clk(clk), .rst_n(rst_n), .prot_pin_n(prot_pin_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .wrsr_data(wrsr_data), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
        .cmd_chip_erase(cmd_chip_erase), .cmd_rdsr(cmd_rdsr),
        .op_addr(op_addr), .op_done(op_done), .status(status),
        .busy(busy), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // v = {rdsr, chip, erase, prog, wrsr, wrdi, wren}
    task automatic issue(input logic [6:0] v);
        @(negedge clk);
        {cmd_rdsr, cmd_chip_erase, cmd_erase, cmd_prog, cmd_wrsr, cmd_wrdi, cmd_wren} = v;
        @(negedge clk);
        {cmd_rdsr, cmd_chip_erase, cmd_erase, cmd_prog, cmd_wrsr, cmd_wrdi, cmd_wren} = '0;
        got_acc = cmd_accept;
        got_rej = cmd_reject;
    endtask

    task automatic finish_op();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        check(!busy && !status[1], "R3 done clears busy/latch",
              {30'd0, busy, status[1]}, 32'd0);
    endtask

    task automatic set_sr(input logic [23:0] d);
        issue(7'b0000001);
        wrsr_data = d;
        issue(7'b0000100);
        check(got_acc && busy, "R1 status write accepted", {30'd0, got_acc, busy}, 32'd3);
        finish_op();
        check(status == (d & MASK), "R1 stored bits", {8'd0, status}, {8'd0, d & MASK});
    endtask

    function automatic bit prot_exp(input int lvl, input bit inv, input int blk);
        bit top;
        if (lvl == 0) top = 0;
        else if (lvl - 1 >= NB) top = 1;
        else top = (blk >= NBLK - (1 << (lvl - 1)));
        return top ^ inv;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 24'd0 && !busy && !cmd_accept && !cmd_reject, "R6 reset state",
              {8'd0, status}, 32'd0);

        // R2 latch set and clear, R10 single-cycle pulse
        issue(7'b0000001);
        check(got_acc && !got_rej && status[1], "R2 wren", {30'd0, got_acc, status[1]}, 32'd3);
        @(negedge clk);
        check(!cmd_accept && !cmd_reject, "R10 one-cycle pulse", {31'd0, cmd_accept}, 32'd0);
        issue(7'b0000010);
        check(got_acc && !status[1], "R2 wrdi", {30'd0, got_acc, status[1]}, 32'd2);

        // R4 latch clear rejects everything
        for (int k = 2; k < 6; k++) begin
            wrsr_data = 24'h0;
            op_addr = '0;
            issue(7'(1 << k));
            check(got_rej && !got_acc && !busy, "R4 no latch reject",
                  {30'd0, got_acc, got_rej}, 32'd1);
        end

        // R1 reserved bits read zero
        set_sr(24'hFFFC3C & ~24'h000180);
        set_sr(24'h000000);

        // R9 busy ignores commands except status read
        issue(7'b0000001);
        op_addr = '0;
        issue(7'b0001000);
        check(got_acc && busy, "R3 program starts busy", {30'd0, got_acc, busy}, 32'd3);
        for (int k = 0; k < 6; k++) begin
            issue(7'(1 << k));
            check(!got_acc && !got_rej && busy && status == 24'h3, "R9 ignored while busy",
                  {6'd0, got_acc, got_rej, status}, 32'h3);
        end
        issue(7'b1000000);
        check(got_acc && busy, "R9 status read while busy", {31'd0, got_acc}, 32'd1);
        finish_op();

        // R8 region sweep
        for (int lvl = 0; lvl < 8; lvl++) begin
            for (int inv = 0; inv < 2; inv++) begin
                set_sr(24'((inv << 14) | (lvl << 2)));
                for (int blk = 0; blk < NBLK; blk++) begin
                    bit p;
                    p = prot_exp(lvl, inv[0], blk);
                    issue(7'b0000001);
                    op_addr = ADDR_W'((blk << BLK_W) | (blk * 37));
                    issue((blk % 2 == 0) ? 7'b0001000 : 7'b0010000);
                    check(got_acc == !p && got_rej == p, "R8 region decision",
                          {30'd0, got_acc, got_rej}, {30'd0, !p, p});
                    if (got_acc) finish_op();
                    else check(!status[1], "R4 reject clears latch", {31'd0, status[1]}, 32'd0);
                end
            end
        end
        set_sr(24'h00007C);
        issue(7'b0000001);
        op_addr = '0;
        issue(7'b0001000);
        check(got_rej, "R8 level 31 whole array", {31'd0, got_rej}, 32'd1);

        // R7 chip erase gate
        for (int lvl = 0; lvl < 4; lvl++) begin
            for (int inv = 0; inv < 2; inv++) begin
                bit ok;
                ok = (lvl == 0) && (inv == 0);
                set_sr(24'((inv << 14) | (lvl << 2)));
                issue(7'b0000001);
                issue(7'b0100000);
                check(got_acc == ok && got_rej == !ok, "R7 chip erase gate",
                      {30'd0, got_acc, got_rej}, {30'd0, ok, !ok});
                if (got_acc) finish_op();
            end
        end

        // R5 lock mode 01 with pin
        set_sr(24'h000088);
        prot_pin_n = 1'b0;
        issue(7'b0000001);
        wrsr_data = 24'h0;
        issue(7'b0000100);
        check(got_rej && status == 24'h000088, "R5 pin low blocks", {8'd0, status}, 32'h88);
        prot_pin_n = 1'b1;
        // move to mode 10 with quad enable and level 3
        set_sr(24'h00030C);
        for (int pin = 0; pin < 2; pin++) begin
            prot_pin_n = pin[0];
            issue(7'b0000001);
            issue(7'b0000100);
            check(got_rej && status == 24'h00030C, "R5 mode 10 blocks", {8'd0, status}, 32'h30C);
        end
        // R6 power cycle releases mode 10, keeps other bits
        issue(7'b0000001);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(status == 24'h00020C, "R6 power cycle", {8'd0, status}, 32'h20C);
        prot_pin_n = 1'b0;
        set_sr(24'h00020C);
        // R5 mode 11 permanent
        set_sr(24'h004184);
        prot_pin_n = 1'b1;
        issue(7'b0000001);
        issue(7'b0000100);
        check(got_rej, "R5 mode 11 blocks", {31'd0, got_rej}, 32'd1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(status == 24'h004184, "R6 mode 11 kept", {8'd0, status}, 32'h4184);
        issue(7'b0000001);
        issue(7'b0000100);
        check(got_rej && status == 24'h004184, "R5 still permanent", {8'd0, status}, 32'h4184);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule